// File: doc/BRIEF.md
# Serial-Bus Configuration Register Bank for a Clock Generator

This block is the two-wire slave that configures a programmable clock source. It watches the serial clock and data lines, recognises its own seven-bit address, accepts a register pointer and data bytes, and returns register contents on reads. It holds two configuration registers. The divider register sets the divider exponent, the dither depth selection and the idle level of the clock output. The address register holds three programmable address bits and the commit mode.

Each accepted change can be copied to a non-volatile store. A level request carries a 16-bit snapshot of both registers and stays high until the store answers with a one-cycle done pulse. While a store is pending, the slave refuses every transfer by not acknowledging its address. Register writes take effect only when a complete byte has been received. A transfer that is cut short by a START or STOP changes nothing.

Top module: `clkcfg_i2c_regs`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal binary 1011 followed by the three address bits of the address register. Bit 0 of the address byte is the direction: 0 means write, 1 means read. Any other address gets no acknowledge, and the rest of that transfer has no effect.
- R2: The divider register sits at pointer 02h and reads back as {2'b11, idle_low, dither, code[3:0]}. `out_lo_mode` = bit 5, `dither_sel` = bit 4, and `div_exp` = code, except that any code above 8 gives 8.
- R3: The address register sits at pointer 0Dh and reads back as {4'hF, commit_manual, sel[2:0]}. Bit 3 selects manual commit mode, and bits 2..0 are the three low address bits.
- R4: With bit 3 of the address register clear, a data write to 02h raises `store_req`. `store_word` = {read value of 02h, read value of 0Dh}.
- R5: With bit 3 set, a write to 02h updates the register but raises no request. A pointer byte of 3Fh raises `store_req` in either mode.
- R6: A data write to 0Dh always raises `store_req`, whatever the commit mode.
- R7: `store_req` stays high until a cycle with `store_done` high, and falls on the next clock. While it is high, every address byte gets no acknowledge and no register changes.
- R8: A read is a pointer write, a repeated START, and the address with the direction bit at 1. The slave then returns the pointed register MSB first. It repeats that value for every byte the master acknowledges. After a master not-acknowledge, it leaves SDA released. SDA is only pulled low and only changes while SCL is low.
- R9: A START or STOP that arrives before the eighth bit of a byte ends the transfer, and no register changes.
- R10: After reset, the divider register holds 10h (div_exp 0, dither_sel 1, out_lo_mode 0) and the address register holds 0h. `store_req` and `sda_oe` are low.
- R11: A pointer other than 02h, 0Dh or 3Fh reads as FFh. Data written to such a pointer is acknowledged but changes nothing and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | Pulls SDA low when high (open-drain) |
| div_exp | output | 4 | Divider exponent, clamped to 8 |
| dither_sel | output | 1 | Dither depth selection bit |
| out_lo_mode | output | 1 | Output held low (1) or floating (0) when stopped |
| store_req | output | 1 | Non-volatile store request, level |
| store_done | input | 1 | One-cycle pulse: store finished |
| store_word | output | 16 | Snapshot of both registers for the store |

## Verification
Two functions can meet in the same transfer: the commit controller arming a store, and the bus engine accepting the next address. The bench provokes this by issuing a write, or the 3Fh command, and then starting a new write before it pulses `store_done`. The new write must go unacknowledged. A cycle-by-cycle model that compares the register outputs and the request on every clock confirms that nothing moved. Once the done pulse arrives, a follow-up transfer must be acknowledged again, and the model judges that the new value lands.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam logic [3:0] DEV_ID  = 4'b1011;
    localparam logic [7:0] PTR_DIV = 8'h02;
    localparam logic [7:0] PTR_ADR = 8'h0D;
    localparam logic [7:0] PTR_CMT = 8'h3F;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RXACK,
        PH_TX,
        PH_TXACK
    } phase_t;

    typedef struct packed {
        logic       lo_mode;
        logic       dith;
        logic [3:0] code;
    } div_reg_t;

    typedef struct packed {
        logic       manual;
        logic [2:0] sel;
    } adr_reg_t;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int FILT_LEN = 3,
    parameter bit RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[0], line_i};
        if (flt_q.sync[1] == flt_q.lvl) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == CW'(FILT_LEN - 1)) begin
            flt_d.lvl = flt_q.sync[1];
            flt_d.cnt = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '{sync: {2{RST_VAL}}, lvl: RST_VAL, cnt: '0};
        end else begin
            flt_q <= flt_d;
        end
    end

    assign line_o = flt_q.lvl;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import clkcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda,
    input  logic [2:0] dev_sel,
    input  logic       busy,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       ev_ptr,
    output logic       ev_data,
    output logic [7:0] ev_val,
    output logic [7:0] ptr
);
    typedef struct packed {
        phase_t     phase;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] tx;
        logic [7:0] ptr;
        logic       is_addr;
        logic       is_ptr;
        logic       rd;
        logic       oe;
        logic       scl_p;
        logic       sda_p;
        logic       ev_ptr;
        logic       ev_data;
    } eng_t;

    eng_t e_d, e_q;
    logic rise, fall, start_c, stop_c;

    assign rise    = scl & ~e_q.scl_p;
    assign fall    = ~scl & e_q.scl_p;
    assign start_c = scl & e_q.scl_p & e_q.sda_p & ~sda;
    assign stop_c  = scl & e_q.scl_p & ~e_q.sda_p & sda;

    always_comb begin
        e_d         = e_q;
        e_d.scl_p   = scl;
        e_d.sda_p   = sda;
        e_d.ev_ptr  = 1'b0;
        e_d.ev_data = 1'b0;
        if (stop_c) begin
            e_d.phase = PH_IDLE;
            e_d.oe    = 1'b0;
        end else if (start_c) begin
            e_d.phase   = PH_RX;
            e_d.cnt     = '0;
            e_d.is_addr = 1'b1;
            e_d.oe      = 1'b0;
        end else begin
            unique case (e_q.phase)
                PH_RX: begin
                    if (rise) begin
                        e_d.sh  = {e_q.sh[6:0], sda};
                        e_d.cnt = e_q.cnt + 4'd1;
                    end else if (fall && e_q.cnt == 4'd8) begin
                        e_d.cnt = '0;
                        if (e_q.is_addr) begin
                            if (e_q.sh[7:1] == {DEV_ID, dev_sel} && !busy) begin
                                e_d.oe      = 1'b1;
                                e_d.rd      = e_q.sh[0];
                                e_d.is_ptr  = ~e_q.sh[0];
                                e_d.is_addr = 1'b0;
                                e_d.phase   = PH_RXACK;
                            end else begin
                                e_d.phase = PH_IDLE;
                            end
                        end else if (busy) begin
                            e_d.phase = PH_IDLE;
                        end else begin
                            e_d.oe    = 1'b1;
                            e_d.phase = PH_RXACK;
                            if (e_q.is_ptr) begin
                                e_d.ptr    = e_q.sh;
                                e_d.ev_ptr = 1'b1;
                                e_d.is_ptr = 1'b0;
                            end else begin
                                e_d.ev_data = 1'b1;
                            end
                        end
                    end
                end
                PH_RXACK: begin
                    if (fall) begin
                        e_d.cnt = '0;
                        if (e_q.rd) begin
                            e_d.tx    = rd_data;
                            e_d.oe    = ~rd_data[7];
                            e_d.phase = PH_TX;
                        end else begin
                            e_d.oe    = 1'b0;
                            e_d.phase = PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (rise) begin
                        e_d.cnt = e_q.cnt + 4'd1;
                    end else if (fall) begin
                        if (e_q.cnt == 4'd8) begin
                            e_d.oe    = 1'b0;
                            e_d.phase = PH_TXACK;
                        end else begin
                            e_d.tx = {e_q.tx[6:0], 1'b1};
                            e_d.oe = ~e_q.tx[6];
                        end
                    end
                end
                PH_TXACK: begin
                    if (rise && sda) begin
                        e_d.phase = PH_IDLE;
                    end else if (fall) begin
                        e_d.cnt   = '0;
                        e_d.tx    = rd_data;
                        e_d.oe    = ~rd_data[7];
                        e_d.phase = PH_TX;
                    end
                end
                default: e_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{phase: PH_IDLE, cnt: '0, sh: '0, tx: '1, ptr: '0,
                     is_addr: 1'b0, is_ptr: 1'b0, rd: 1'b0, oe: 1'b0,
                     scl_p: 1'b1, sda_p: 1'b1, ev_ptr: 1'b0, ev_data: 1'b0};
        end else begin
            e_q <= e_d;
        end
    end

    assign sda_oe  = e_q.oe;
    assign ev_ptr  = e_q.ev_ptr;
    assign ev_data = e_q.ev_data;
    assign ev_val  = e_q.sh;
    assign ptr     = e_q.ptr;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import clkcfg_pkg::*;
#(
    parameter logic [5:0] DIV_RST = 6'h10,
    parameter logic [3:0] ADR_RST = 4'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_ptr,
    input  logic        ev_data,
    input  logic [7:0]  ev_val,
    input  logic [7:0]  ptr,
    input  logic        store_done,
    output logic [7:0]  rd_data,
    output logic [2:0]  dev_sel,
    output logic [3:0]  div_exp,
    output logic        dither_sel,
    output logic        out_lo_mode,
    output logic        store_req,
    output logic [15:0] store_word
);
    localparam logic [3:0] EXP_MAX = 4'd8;

    typedef struct packed {
        div_reg_t div;
        adr_reg_t adr;
        logic     req;
    } bank_t;

    bank_t b_d, b_q;
    logic [7:0] div_rd, adr_rd;

    assign div_rd = {2'b11, b_q.div};
    assign adr_rd = {4'hF, b_q.adr};

    always_comb begin
        b_d = b_q;
        if (b_q.req && store_done) begin
            b_d.req = 1'b0;
        end
        if (ev_ptr && ev_val == PTR_CMT) begin
            b_d.req = 1'b1;
        end
        if (ev_data) begin
            if (ptr == PTR_DIV) begin
                b_d.div = div_reg_t'(ev_val[5:0]);
                if (!b_q.adr.manual) begin
                    b_d.req = 1'b1;
                end
            end else if (ptr == PTR_ADR) begin
                b_d.adr = adr_reg_t'(ev_val[3:0]);
                b_d.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '{div: div_reg_t'(DIV_RST), adr: adr_reg_t'(ADR_RST), req: 1'b0};
        end else begin
            b_q <= b_d;
        end
    end

    always_comb begin
        if (ptr == PTR_DIV) begin
            rd_data = div_rd;
        end else if (ptr == PTR_ADR) begin
            rd_data = adr_rd;
        end else begin
            rd_data = 8'hFF;
        end
    end

    assign dev_sel     = b_q.adr.sel;
    assign div_exp     = (b_q.div.code > EXP_MAX) ? EXP_MAX : b_q.div.code;
    assign dither_sel  = b_q.div.dith;
    assign out_lo_mode = b_q.div.lo_mode;
    assign store_req   = b_q.req;
    assign store_word  = {div_rd, adr_rd};
endmodule

// File: rtl/clkcfg_i2c_regs.sv
module clkcfg_i2c_regs #(
    parameter int         FILT_LEN = 3,
    parameter logic [5:0] DIV_RST  = 6'h10,
    parameter logic [3:0] ADR_RST  = 4'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic [3:0]  div_exp,
    output logic        dither_sel,
    output logic        out_lo_mode,
    output logic        store_req,
    input  logic        store_done,
    output logic [15:0] store_word
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] line_raw, line_flt;
    logic scl_f, sda_f;
    logic ev_ptr, ev_data;
    logic [7:0] ev_val, ptr, rd_data;
    logic [2:0] dev_sel;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_flt
        i2c_glitch_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(line_raw[g]),
            .line_o(line_flt[g])
        );
    end

    assign scl_f = line_flt[0];
    assign sda_f = line_flt[1];

    i2c_slave_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl    (scl_f),
        .sda    (sda_f),
        .dev_sel(dev_sel),
        .busy   (store_req),
        .rd_data(rd_data),
        .sda_oe (sda_oe),
        .ev_ptr (ev_ptr),
        .ev_data(ev_data),
        .ev_val (ev_val),
        .ptr    (ptr)
    );

    cfg_reg_bank #(.DIV_RST(DIV_RST), .ADR_RST(ADR_RST)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_ptr     (ev_ptr),
        .ev_data    (ev_data),
        .ev_val     (ev_val),
        .ptr        (ptr),
        .store_done (store_done),
        .rd_data    (rd_data),
        .dev_sel    (dev_sel),
        .div_exp    (div_exp),
        .dither_sel (dither_sel),
        .out_lo_mode(out_lo_mode),
        .store_req  (store_req),
        .store_word (store_word)
    );
endmodule

// File: rtl/clkcfg_i2c_regs_chk.sv
module clkcfg_i2c_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_oe,
    input logic       store_req,
    input logic       store_done,
    input logic [3:0] div_exp,
    input logic       dither_sel,
    input logic       out_lo_mode
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R7: a pending request is held until the done pulse
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && !store_done) |=> store_req);

    // R7: the request only falls after a done pulse
    assert_req_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(store_req)) |-> $past(store_done));

    // R7: no register output moves while a store is pending
    assert_frozen_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> $stable({div_exp, dither_sel, out_lo_mode}));

    // R8: the slave changes its SDA drive only while SCL is low
    assert_sda_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$stable(sda_oe)) |-> !scl_f);
endmodule

bind clkcfg_i2c_regs clkcfg_i2c_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f      (scl_f),
    .sda_oe     (sda_oe),
    .store_req  (store_req),
    .store_done (store_done),
    .div_exp    (div_exp),
    .dither_sel (dither_sel),
    .out_lo_mode(out_lo_mode)
);

// File: tb/sim_clkcfg_i2c_regs.sv
`timescale 1ns/1ps
module sim_clkcfg_i2c_regs;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic store_done = 1'b0;
    logic sda_oe, dither_sel, out_lo_mode, store_req;
    logic [3:0] div_exp;
    logic [15:0] store_word;
    logic sda_line;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    clkcfg_i2c_regs u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .div_exp(div_exp), .dither_sel(dither_sel),
        .out_lo_mode(out_lo_mode), .store_req(store_req),
        .store_done(store_done), .store_word(store_word)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;
    logic [5:0] m_div = 6'h10;
    logic [3:0] m_adr = 4'h0;
    logic       m_req = 1'b0;

    function automatic logic [3:0] m_exp();
        return (m_div[3:0] > 4'd8) ? 4'd8 : m_div[3:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            n_cmp++;
            if (div_exp !== m_exp() || dither_sel !== m_div[4] ||
                out_lo_mode !== m_div[5] || store_req !== m_req) begin
                n_bad++;
                $display("FAIL R2/R7 per-clock actual=%h_%b_%b_%b expected=%h_%b_%b_%b",
                         div_exp, dither_sel, out_lo_mode, store_req,
                         m_exp(), m_div[4], m_div[5], m_req);
            end
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic b_start();
        sda_m = 1'b1; w(H); scl_m = 1'b1; w(H); sda_m = 1'b0; w(H); scl_m = 1'b0; w(4);
    endtask

    task automatic b_stop();
        sda_m = 1'b0; w(H); scl_m = 1'b1; w(H); sda_m = 1'b1; w(H);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = v[i]; w(H); scl_m = 1'b1; w(H); scl_m = 1'b0; w(4);
        end
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        send_bits(v, 8);
        sda_m = 1'b1; w(H); scl_m = 1'b1; w(H/2);
        ack = (sda_line == 1'b0);
        w(H/2); scl_m = 1'b0; w(4);
    endtask

    task automatic recv_byte(input bit m_ack, output logic [7:0] v);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(H); scl_m = 1'b1; w(H/2); v[i] = sda_line; w(H/2); scl_m = 1'b0; w(4);
        end
        sda_m = m_ack ? 1'b0 : 1'b1;
        w(H); scl_m = 1'b1; w(H); scl_m = 1'b0; w(4); sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev(input logic [2:0] sel, input bit rd);
        return {4'b1011, sel, rd};
    endfunction

    task automatic model_wr(input logic [7:0] p, input logic [7:0] v);
        if (p == 8'h02) begin
            m_div = v[5:0];
            if (!m_adr[3]) m_req = 1'b1;
        end else if (p == 8'h0D) begin
            m_adr = v[3:0];
            m_req = 1'b1;
        end
    endtask

    // full register write; model updated only if all three bytes were taken
    task automatic wr_reg(input logic [2:0] sel, input logic [7:0] p, input logic [7:0] v,
                          output bit a0, output bit a1, output bit a2);
        cmp_en = 1'b0;
        a1 = 1'b0; a2 = 1'b0;
        b_start();
        send_byte(dev(sel, 1'b0), a0);
        if (a0) send_byte(p, a1);
        if (a1) send_byte(v, a2);
        b_stop();
        if (a2) model_wr(p, v);
        w(10);
        cmp_en = 1'b1;
    endtask

    task automatic rd_reg(input logic [7:0] p, input int nbytes, output bit a0, output logic [7:0] v);
        bit a1, a2;
        cmp_en = 1'b0;
        v = 8'h00;
        b_start();
        send_byte(dev(m_adr[2:0], 1'b0), a0);
        send_byte(p, a1);
        b_start();
        send_byte(dev(m_adr[2:0], 1'b1), a2);
        for (int k = 0; k < nbytes; k++) begin
            recv_byte(k != nbytes - 1, v);
            check("R8 repeated byte", v, (p == 8'h02) ? {2'b11, m_div} :
                  (p == 8'h0D) ? {4'hF, m_adr} : 8'hFF);
        end
        a0 = a0 & a1 & a2;
        w(H);
        check("R8 SDA released after NACK", sda_oe, 1'b0);
        b_stop();
        w(10);
        cmp_en = 1'b1;
    endtask

    task automatic finish_store();
        cmp_en = 1'b0;
        w(5);
        store_done = 1'b1; w(1); store_done = 1'b0;
        m_req = 1'b0;
        w(3);
        check("R7 request cleared by done", store_req, 1'b0);
        cmp_en = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        bit a0, a1, a2;
        logic [7:0] v;
        w(5); rst_n = 1'b1; w(5);
        // R10 reset state
        check("R10 div_exp", div_exp, 4'd0);
        check("R10 dither_sel", dither_sel, 1'b1);
        check("R10 out_lo_mode", out_lo_mode, 1'b0);
        check("R10 store_req", store_req, 1'b0);
        check("R10 sda_oe", sda_oe, 1'b0);
        cmp_en = 1'b1;

        rd_reg(8'h02, 1, a0, v);
        check("R2 read default divider", v, 8'hD0);
        check("R1 read acked", a0, 1'b1);
        rd_reg(8'h0D, 1, a0, v);
        check("R3 read default address", v, 8'hF0);

        // R4 automatic commit
        wr_reg(3'd0, 8'h02, 8'h35, a0, a1, a2);
        check("R1 matching address acked", {a0, a1, a2}, 3'b111);
        check("R4 request raised", store_req, 1'b1);
        check("R4 snapshot", store_word, 16'hF5F0);
        check("R2 div_exp", div_exp, 4'd5);
        finish_store();

        // R2 clamp
        wr_reg(3'd0, 8'h02, 8'h0C, a0, a1, a2);
        check("R2 clamp to 8", div_exp, 4'd8);
        finish_store();

        // R1 wrong address
        wr_reg(3'd1, 8'h02, 8'h01, a0, a1, a2);
        check("R1 wrong address not acked", a0, 1'b0);
        check("R1 no change", div_exp, 4'd8);

        // R6 address register: manual mode, sel 3
        wr_reg(3'd0, 8'h0D, 8'h0B, a0, a1, a2);
        check("R6 address write acked", a2, 1'b1);
        check("R6 request in any mode", store_req, 1'b1);
        check("R3 snapshot of address reg", store_word[7:0], 8'hFB);
        finish_store();
        wr_reg(3'd0, 8'h02, 8'h01, a0, a1, a2);
        check("R1 old address refused", a0, 1'b0);

        // R5 manual mode write: no request
        wr_reg(3'd3, 8'h02, 8'h2A, a0, a1, a2);
        check("R5 write acked", a2, 1'b1);
        check("R5 no request", store_req, 1'b0);
        check("R2 out_lo_mode", out_lo_mode, 1'b1);
        rd_reg(8'h02, 1, a0, v);
        check("R8 readback", v, 8'hEA);

        // R5 commit command, R7 busy refusal
        cmp_en = 1'b0;
        b_start(); send_byte(dev(3'd3, 1'b0), a0); send_byte(8'h3F, a1); b_stop();
        m_req = 1'b1; w(10); cmp_en = 1'b1;
        check("R5 command acked", a1, 1'b1);
        check("R5 command raises request", store_req, 1'b1);
        wr_reg(3'd3, 8'h02, 8'h03, a0, a1, a2);
        check("R7 address refused while busy", a0, 1'b0);
        check("R7 register unchanged", div_exp, 4'd8);
        finish_store();
        wr_reg(3'd3, 8'h02, 8'h03, a0, a1, a2);
        check("R7 normal after done", {a0, a2}, 2'b11);
        check("R7 new value", div_exp, 4'd3);

        // R8 multi-byte read
        rd_reg(8'h0D, 3, a0, v);
        check("R8 read acked", a0, 1'b1);

        // R11 unknown pointer
        rd_reg(8'h05, 1, a0, v);
        check("R11 unknown reads FF", v, 8'hFF);
        wr_reg(3'd3, 8'h05, 8'h00, a0, a1, a2);
        check("R11 write acked", a2, 1'b1);
        check("R11 no request", store_req, 1'b0);

        // R9 abort by STOP mid-byte, then START mid-byte
        cmp_en = 1'b0;
        b_start(); send_byte(dev(3'd3, 1'b0), a0); send_byte(8'h02, a1);
        send_bits(8'h07, 4); b_stop();
        w(10); cmp_en = 1'b1;
        check("R9 STOP abort keeps value", div_exp, 4'd3);
        cmp_en = 1'b0;
        b_start(); send_byte(dev(3'd3, 1'b0), a0); send_byte(8'h02, a1);
        send_bits(8'h07, 5); b_start(); b_stop();
        w(10); cmp_en = 1'b1;
        check("R9 START abort keeps value", div_exp, 4'd3);
        rd_reg(8'h02, 1, a0, v);
        check("R9 readback", v, 8'hC3);

        // R6 return to automatic mode
        wr_reg(3'd3, 8'h0D, 8'h00, a0, a1, a2);
        check("R6 request", store_req, 1'b1);
        check("R6 snapshot", store_word, 16'hC3F0);
        finish_store();

        w(20);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule